// File: doc/BRIEF.md
# Instruction Fetch Line-Fill Buffer

This block sits between an instruction cache and the bus when an instruction fetch misses. It reads the missing 16-byte line as a four-beat burst. The burst starts at the requested long word and wraps around inside the line. The requested word goes to the fetch unit in the same cycle its beat arrives. Each beat is also kept in a line buffer that has one valid bit per word. While the burst runs, the fetch unit can keep reading in order through the line, and each word is served as soon as its beat is present. Any request that breaks the order, or that falls outside the line, waits until the burst has ended.

When all beats are in, the line goes to the cache array as a single write. Two conditions prevent the write. The first is a cache-inhibit on the opening beat; the burst still completes and in-order reads are still served. The second is a bus error. An error on the opening beat is not reported at once. It is held against the word that was requested and is raised only if that exact word is asked for again. A request to any other word of the line starts a fresh fill.

Top module: `ifill_line_buffer`

## Requirements
- R1: A miss seen while idle raises `bus_req` in the next cycle. Each beat address is the line base plus a word offset that starts at the requested word and then counts up modulo 4. The byte bits [1:0] of the beat address are zero, and the address holds steady until `bus_ack`.
- R2: The requested word is returned on `fetch_data` with `fetch_ack` in the same cycle as its beat's `bus_ack`.
- R3: During a fill, a request for the next long word after the last one served in that line is acknowledged once its beat has arrived. Arrival means either an earlier beat or the beat in the current cycle.
- R4: During a fill, a request that breaks the order or addresses another line gets no `fetch_ack` until the burst ends. It is then handled as a new miss.
- R5: The cycle after the fourth good beat, `lw_en` is high for one cycle. `lw_line` carries the line address and `lw_data` holds word offset i in bits [32*i+31:32*i].
- R6: `bus_ci` high on the opening beat still lets the burst and the in-order hits finish, but no `lw_en` follows.
- R7: `bus_ci` on beats two to four has no effect, and the line is written.
- R8: `bus_err` with `bus_ack` ends the burst: `bus_req` is low in the next cycle, and that beat's data is not forwarded.
- R9: After an error on the opening beat, the next request for the same word gets `fetch_ack` with `fetch_err` high and `fetch_data` zero. This happens only once, and no bus activity is started for it.
- R10: After an error on the opening beat, a request to a different word starts a new fill with no error flag.
- R11: An error on beats two to four discards the buffer. No line write follows, and no error is ever reported for it.
- R12: During reset and after it, `bus_req`, `fetch_ack` and `lw_en` are low, and `fetch_err` is never high without `fetch_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request that missed the cache array, held until acknowledged |
| fetch_word | input | ADDR_W-2 | Long-word address of the request |
| fetch_ack | output | 1 | Request served this cycle |
| fetch_data | output | DATA_W | Returned instruction word |
| fetch_err | output | 1 | Deferred bus error reported for this word |
| bus_req | output | 1 | Burst in progress |
| bus_addr | output | ADDR_W | Byte address of the current beat |
| bus_ack | input | 1 | Beat completes this cycle |
| bus_data | input | DATA_W | Beat data |
| bus_ci | input | 1 | Cache-inhibit, sampled on the opening beat only |
| bus_err | input | 1 | Bus error on this beat |
| lw_en | output | 1 | Write the completed line into the cache array |
| lw_line | output | ADDR_W-4 | Line address of the write |
| lw_data | output | 4*DATA_W | Line data in word-offset order |

## Verification
The properties assume that `bus_ack`, `bus_ci` and `bus_err` mean something only while `bus_req` is high. They also assume that the fetch unit holds `fetch_req` and `fetch_word` steady until it sees `fetch_ack`. The bench keeps to both assumptions. Its bus responder takes a beat code from its script only in cycles where `bus_req` is high, and it drives zeros otherwise. Its fetch driver moves to the next queued address only after an acknowledged cycle, except in one deliberate flush after an opening-beat error, which stands for the fetch unit dropping a request.

// File: rtl/ifill_pkg.sv
package ifill_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_FILL = 2'd1,
    FS_DONE = 2'd2
  } fill_state_t;

  // Word offset of beat number 'beat' in a burst that begins at 'start'.
  function automatic int unsigned wrap_ofs(input int unsigned start,
                                           input int unsigned beat,
                                           input int unsigned words);
    return (start + beat) % words;
  endfunction

  // True when 'ofs' is the highest word offset of a line.
  function automatic bit is_line_end(input int unsigned ofs,
                                     input int unsigned words);
    return ofs == words - 1;
  endfunction

endpackage

// File: rtl/ifill_fill_ctrl.sv
module ifill_fill_ctrl
  import ifill_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int BYTE_W     = 2,
  localparam int WOFS_W    = $clog2(LINE_WORDS),
  localparam int WORD_W    = ADDR_W - BYTE_W,
  localparam int LINE_W    = WORD_W - WOFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              bus_ack,
  input  logic              bus_ci,
  input  logic              bus_err,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              start_fill,
  output logic              beat_ok,
  output logic              beat_bad,
  output logic              discard,
  output logic [WOFS_W-1:0] beat_ofs,
  output logic              err_hit,
  output logic              line_we
);

  fill_state_t       state;
  logic [LINE_W-1:0] miss_line;
  logic [WOFS_W-1:0] start_ofs;
  logic [WOFS_W-1:0] beat_cnt;
  logic              inhibit;
  logic              err_vld;
  logic [WORD_W-1:0] err_word;
  logic              last_beat;
  logic              first_beat;

  assign err_hit    = (state == FS_IDLE) && fetch_req && err_vld &&
                      (fetch_word == err_word);
  assign start_fill = (state == FS_IDLE) && fetch_req && !err_hit;
  assign bus_req    = (state == FS_FILL);
  assign beat_ofs   = WOFS_W'(wrap_ofs(32'(start_ofs), 32'(beat_cnt), LINE_WORDS));
  assign bus_addr   = {miss_line, beat_ofs, {BYTE_W{1'b0}}};
  assign beat_ok    = bus_req && bus_ack && !bus_err;
  assign beat_bad   = bus_req && bus_ack && bus_err;
  assign first_beat = (beat_cnt == '0);
  assign last_beat  = (beat_cnt == WOFS_W'(LINE_WORDS - 1));
  assign discard    = beat_bad || (state == FS_DONE);
  assign line_we    = (state == FS_DONE) && !inhibit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= FS_IDLE;
      miss_line <= '0;
      start_ofs <= '0;
      beat_cnt  <= '0;
      inhibit   <= 1'b0;
      err_vld   <= 1'b0;
      err_word  <= '0;
    end else begin
      unique case (state)
        FS_IDLE: begin
          if (err_hit) begin
            err_vld <= 1'b0;
          end else if (start_fill) begin
            state     <= FS_FILL;
            miss_line <= fetch_word[WORD_W-1:WOFS_W];
            start_ofs <= fetch_word[WOFS_W-1:0];
            beat_cnt  <= '0;
            inhibit   <= 1'b0;
            err_vld   <= 1'b0;
          end
        end
        FS_FILL: begin
          if (beat_bad) begin
            state <= FS_IDLE;
            if (first_beat) begin
              err_vld  <= 1'b1;
              err_word <= {miss_line, start_ofs};
            end
          end else if (beat_ok) begin
            if (first_beat) inhibit <= bus_ci;
            if (last_beat) state <= FS_DONE;
            else           beat_cnt <= beat_cnt + 1'b1;
          end
        end
        FS_DONE: state <= FS_IDLE;
        default: state <= FS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ifill_line_store.sv
module ifill_line_store #(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINE_W     = 28,
  localparam int WOFS_W    = $clog2(LINE_WORDS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         open,
  input  logic [LINE_W-1:0]            open_line,
  input  logic                         discard,
  input  logic                         wr_en,
  input  logic [WOFS_W-1:0]            wr_ofs,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [LINE_WORDS-1:0]        vld,
  output logic [LINE_WORDS*DATA_W-1:0] data,
  output logic [LINE_W-1:0]            tag,
  output logic                         tag_vld
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld     <= '0;
      tag     <= '0;
      tag_vld <= 1'b0;
    end else if (open) begin
      vld     <= '0;
      tag     <= open_line;
      tag_vld <= 1'b1;
    end else if (discard) begin
      vld     <= '0;
      tag     <= '0;
      tag_vld <= 1'b0;
    end else if (wr_en) begin
      vld[wr_ofs] <= 1'b1;
    end
  end

  for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data[i*DATA_W +: DATA_W] <= '0;
      end else if (wr_en && (wr_ofs == WOFS_W'(i))) begin
        data[i*DATA_W +: DATA_W] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/ifill_fetch_port.sv
module ifill_fetch_port
  import ifill_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 30,
  localparam int WOFS_W    = $clog2(LINE_WORDS),
  localparam int LINE_W    = WORD_W - WOFS_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fill_active,
  input  logic                         open,
  input  logic                         fetch_req,
  input  logic [WORD_W-1:0]            fetch_word,
  input  logic [LINE_W-1:0]            tag,
  input  logic                         tag_vld,
  input  logic [LINE_WORDS-1:0]        vld,
  input  logic [LINE_WORDS*DATA_W-1:0] buf_data,
  input  logic                         beat_ok,
  input  logic [WOFS_W-1:0]            beat_ofs,
  input  logic [DATA_W-1:0]            bus_data,
  input  logic                         err_hit,
  output logic                         fetch_ack,
  output logic [DATA_W-1:0]            fetch_data,
  output logic                         fetch_err,
  output logic                         buf_hit
);

  logic [WORD_W-1:0] exp_word;
  logic              exp_live;
  logic [WOFS_W-1:0] req_ofs;
  logic              in_line;
  logic              in_order;
  logic              from_buf;
  logic              from_bus;

  assign req_ofs  = fetch_word[WOFS_W-1:0];
  assign in_line  = tag_vld && (fetch_word[WORD_W-1:WOFS_W] == tag);
  assign in_order = fill_active && exp_live && fetch_req && in_line &&
                    (fetch_word == exp_word);
  assign from_buf = vld[req_ofs];
  assign from_bus = beat_ok && (beat_ofs == req_ofs);
  assign buf_hit  = in_order && (from_buf || from_bus);

  assign fetch_ack  = buf_hit || err_hit;
  assign fetch_err  = err_hit;
  assign fetch_data = !buf_hit ? '0 :
                      from_buf ? buf_data[req_ofs*DATA_W +: DATA_W] : bus_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_word <= '0;
      exp_live <= 1'b0;
    end else if (open) begin
      exp_word <= fetch_word;
      exp_live <= 1'b1;
    end else if (buf_hit) begin
      if (is_line_end(32'(exp_word[WOFS_W-1:0]), LINE_WORDS)) exp_live <= 1'b0;
      else                                                     exp_word <= exp_word + 1'b1;
    end
  end

endmodule

// File: rtl/ifill_line_buffer.sv
module ifill_line_buffer #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int BYTE_W    = $clog2(DATA_W / 8),
  localparam int WOFS_W    = $clog2(LINE_WORDS),
  localparam int WORD_W    = ADDR_W - BYTE_W,
  localparam int LINE_LSB  = BYTE_W + WOFS_W,
  localparam int LINE_W    = ADDR_W - LINE_LSB
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fetch_req,
  input  logic [WORD_W-1:0]            fetch_word,
  output logic                         fetch_ack,
  output logic [DATA_W-1:0]            fetch_data,
  output logic                         fetch_err,
  output logic                         bus_req,
  output logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_ack,
  input  logic [DATA_W-1:0]            bus_data,
  input  logic                         bus_ci,
  input  logic                         bus_err,
  output logic                         lw_en,
  output logic [LINE_W-1:0]            lw_line,
  output logic [LINE_WORDS*DATA_W-1:0] lw_data
);

  logic                         start_fill;
  logic                         beat_ok;
  logic                         beat_bad;
  logic                         discard;
  logic [WOFS_W-1:0]            beat_ofs;
  logic                         err_hit;
  logic                         buf_hit;
  logic [LINE_WORDS-1:0]        buf_vld;
  logic [LINE_WORDS*DATA_W-1:0] buf_data;
  logic [LINE_W-1:0]            buf_tag;
  logic                         tag_vld;

  ifill_fill_ctrl #(
    .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .BYTE_W(BYTE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_word(fetch_word),
    .bus_ack(bus_ack), .bus_ci(bus_ci), .bus_err(bus_err),
    .bus_req(bus_req), .bus_addr(bus_addr),
    .start_fill(start_fill), .beat_ok(beat_ok), .beat_bad(beat_bad),
    .discard(discard), .beat_ofs(beat_ofs), .err_hit(err_hit),
    .line_we(lw_en)
  );

  ifill_line_store #(
    .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .LINE_W(LINE_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .open(start_fill), .open_line(fetch_word[WORD_W-1:WOFS_W]),
    .discard(discard),
    .wr_en(beat_ok), .wr_ofs(beat_ofs), .wr_data(bus_data),
    .vld(buf_vld), .data(buf_data), .tag(buf_tag), .tag_vld(tag_vld)
  );

  ifill_fetch_port #(
    .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)
  ) u_port (
    .clk(clk), .rst_n(rst_n),
    .fill_active(bus_req), .open(start_fill),
    .fetch_req(fetch_req), .fetch_word(fetch_word),
    .tag(buf_tag), .tag_vld(tag_vld), .vld(buf_vld), .buf_data(buf_data),
    .beat_ok(beat_ok), .beat_ofs(beat_ofs), .bus_data(bus_data),
    .err_hit(err_hit),
    .fetch_ack(fetch_ack), .fetch_data(fetch_data), .fetch_err(fetch_err),
    .buf_hit(buf_hit)
  );

  assign lw_line = buf_tag;
  assign lw_data = buf_data;

endmodule

// File: rtl/ifill_checker.sv
module ifill_checker #(
  parameter int ADDR_W   = 32,
  parameter int LINE_LSB = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_ack,
  input logic              fetch_err,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              lw_en,
  input logic              buf_hit,
  input logic              tag_vld
);

  a_r12_err_only_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |-> fetch_ack);

  a_r8_error_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_err) |=> !bus_req);

  a_r5_write_after_good_beat: assert property (@(posedge clk) disable iff (!rst_n)
    lw_en |-> ($past(bus_req && bus_ack && !bus_err) && tag_vld));

  a_r1_addr_held_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));

  a_r1_burst_stays_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !bus_err) |=>
      (!bus_req || (bus_addr[ADDR_W-1:LINE_LSB] == $past(bus_addr[ADDR_W-1:LINE_LSB]))));

  a_r3_hits_only_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    buf_hit |-> bus_req);

  a_r4_no_ack_on_line_write: assert property (@(posedge clk) disable iff (!rst_n)
    lw_en |-> !fetch_ack);

endmodule

bind ifill_line_buffer ifill_checker #(
  .ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .fetch_ack(fetch_ack), .fetch_err(fetch_err),
  .bus_req(bus_req), .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_err(bus_err),
  .lw_en(lw_en), .buf_hit(buf_hit), .tag_vld(tag_vld)
);

// File: tb/ifill_line_buffer_test.sv
`timescale 1ns/1ps
module ifill_line_buffer_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fetch_req = 1'b0;
  logic [29:0]  fetch_word = '0;
  logic         fetch_ack, fetch_err;
  logic [31:0]  fetch_data;
  logic         bus_req;
  logic [31:0]  bus_addr;
  logic         bus_ack = 1'b0, bus_ci = 1'b0, bus_err = 1'b0;
  logic [31:0]  bus_data;
  logic         lw_en;
  logic [27:0]  lw_line;
  logic [127:0] lw_data;

  always #10 clk = ~clk;

  ifill_line_buffer uut (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_word(fetch_word),
    .fetch_ack(fetch_ack), .fetch_data(fetch_data), .fetch_err(fetch_err),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_ack(bus_ack),
    .bus_data(bus_data), .bus_ci(bus_ci), .bus_err(bus_err),
    .lw_en(lw_en), .lw_line(lw_line), .lw_data(lw_data)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_0000;
  endfunction
  assign bus_data = mem_word(bus_addr);

  int checks = 0, fails = 0;
  int lw_cnt = 0, errf_cnt = 0, ack_cnt = 0;
  logic [31:0] fq[$];
  int          bq[$];   // 0 none, 1 ack, 2 ack+inhibit, 3 ack+error
  bit          took = 1'b0;

  // behavioural reference state
  int          m_mode = 0;  // 0 idle, 1 burst, 2 line write
  logic [27:0] m_line;
  int          m_start, m_beats;
  bit          m_ci;
  bit [3:0]    m_have;
  logic [31:0] m_w[4];
  logic [29:0] m_exp;
  bit          m_live;
  bit          m_errv = 0;
  logic [29:0] m_errw;
  bit          e_ack, e_err, e_hit, e_errhit, e_breq, e_lw;
  logic [31:0] e_data, e_baddr;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic drive_fetch();
    fetch_req  = (fq.size() != 0);
    fetch_word = (fq.size() != 0) ? fq[0][31:2] : '0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int wd, ro;
      bit seq, good;
      wd = (m_start + m_beats) % 4;
      ro = int'(fetch_word[1:0]);
      e_breq   = (m_mode == 1);
      e_baddr  = {m_line, wd[1:0], 2'b00};
      e_errhit = (m_mode == 0) && fetch_req && m_errv && (fetch_word == m_errw);
      good     = (m_mode == 1) && bus_ack && !bus_err;
      seq      = (m_mode == 1) && m_live && fetch_req && (fetch_word == m_exp);
      e_hit    = seq && (m_have[ro] || (good && wd == ro));
      e_ack    = e_hit || e_errhit;
      e_err    = e_errhit;
      e_data   = !e_hit ? 32'h0 : (m_have[ro] ? m_w[ro] : bus_data);
      e_lw     = (m_mode == 2) && !m_ci;
      chk(bus_req == e_breq, "R8", "bus_req", 128'(bus_req), 128'(e_breq));
      if (e_breq) chk(bus_addr == e_baddr, "R1", "bus_addr", 128'(bus_addr), 128'(e_baddr));
      chk(fetch_ack == e_ack, "R3", "fetch_ack", 128'(fetch_ack), 128'(e_ack));
      chk(fetch_err == e_err, "R9", "fetch_err", 128'(fetch_err), 128'(e_err));
      if (e_ack) chk(fetch_data == e_data, "R2", "fetch_data", 128'(fetch_data), 128'(e_data));
      chk(lw_en == e_lw, "R5", "lw_en", 128'(lw_en), 128'(e_lw));
      if (e_lw) begin
        chk(lw_line == m_line, "R5", "lw_line", 128'(lw_line), 128'(m_line));
        chk(lw_data == {m_w[3], m_w[2], m_w[1], m_w[0]}, "R5", "lw_data",
            lw_data, {m_w[3], m_w[2], m_w[1], m_w[0]});
      end
      took = e_ack;
      lw_cnt   += int'(lw_en);
      ack_cnt  += int'(fetch_ack);
      errf_cnt += int'(fetch_ack && fetch_err);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_errv = 0; m_live = 0; m_have = '0;
    end else begin
      case (m_mode)
        0: begin
          if (e_errhit) m_errv = 0;
          else if (fetch_req) begin
            m_mode = 1; m_line = fetch_word[29:2]; m_start = int'(fetch_word[1:0]);
            m_beats = 0; m_ci = 0; m_have = '0; m_errv = 0;
            m_exp = fetch_word; m_live = 1;
          end
        end
        1: begin
          int wd;
          wd = (m_start + m_beats) % 4;
          if (e_hit) begin
            if (m_exp[1:0] == 2'd3) m_live = 0;
            else m_exp = m_exp + 30'd1;
          end
          if (bus_ack) begin
            if (bus_err) begin
              m_mode = 0; m_have = '0;
              if (m_beats == 0) begin m_errv = 1; m_errw = {m_line, 2'(m_start)}; end
            end else begin
              m_have[wd] = 1; m_w[wd] = bus_data;
              if (m_beats == 0) m_ci = bus_ci;
              if (m_beats == 3) m_mode = 2; else m_beats++;
            end
          end
        end
        default: m_mode = 0;
      endcase
    end
  end

  always @(posedge clk) begin
    int code;
    #1;
    if (took) begin
      if (fq.size() != 0) void'(fq.pop_front());
      took = 1'b0;
    end
    drive_fetch();
    code = 0;
    if (bus_req && bq.size() != 0) code = bq.pop_front();
    bus_ack = (code != 0);
    bus_ci  = (code == 2);
    bus_err = (code == 3);
  end

  task automatic clr();
    lw_cnt = 0; errf_cnt = 0; ack_cnt = 0;
  endtask

  task automatic settle();
    while (fq.size() != 0 || bq.size() != 0 || bus_req) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic push_beats(input int n, input int code);
    for (int i = 0; i < n; i++) bq.push_back(code);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] a;
    repeat (3) @(negedge clk);
    chk(!bus_req && !fetch_ack && !lw_en, "R12", "reset outputs",
        128'({bus_req, fetch_ack, lw_en}), 128'(0));
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!bus_req && !fetch_ack && !lw_en, "R12", "idle outputs",
        128'({bus_req, fetch_ack, lw_en}), 128'(0));

    // R1 R2 R3 R5: every starting offset, in-order reads, gaps on the bus
    for (int o = 0; o < 4; o++) begin
      clr();
      a = 32'h0000_1000 + 32'(o) * 32'h40;
      for (int k = o; k < 4; k++) fq.push_back(a + 32'(k) * 4);
      bq.push_back(0); bq.push_back(1); bq.push_back(0);
      push_beats(3, 1);
      settle();
      chk(lw_cnt == 1, "R5", "line writes", 128'(lw_cnt), 128'(1));
      chk(ack_cnt == 4 - o, "R3", "in-order hits", 128'(ack_cnt), 128'(4 - o));
    end

    // R4: out-of-order request inside the line stalls, then misses again
    clr();
    a = 32'h0000_2000;
    fq.push_back(a + 8); fq.push_back(a);
    push_beats(8, 1);
    settle();
    chk(lw_cnt == 2 && ack_cnt == 2, "R4", "reorder stall fills",
        128'({lw_cnt, ack_cnt}), 128'({32'd2, 32'd2}));

    // R4: request to another line stalls during the burst
    clr();
    fq.push_back(a + 32'h100); fq.push_back(a + 32'h204);
    push_beats(8, 1);
    settle();
    chk(lw_cnt == 2 && ack_cnt == 2, "R4", "other line stall",
        128'({lw_cnt, ack_cnt}), 128'({32'd2, 32'd2}));

    // R6: inhibit on the opening beat
    clr();
    a = 32'h0000_3000;
    for (int k = 0; k < 4; k++) fq.push_back(a + 32'(k) * 4);
    bq.push_back(2); push_beats(3, 1);
    settle();
    chk(lw_cnt == 0, "R6", "inhibited line write", 128'(lw_cnt), 128'(0));
    chk(ack_cnt == 4, "R6", "hits under inhibit", 128'(ack_cnt), 128'(4));

    // R7: inhibit on later beats is ignored
    for (int b = 1; b < 4; b++) begin
      clr();
      fq.push_back(a + 32'h40 + 32'(b) * 4);
      for (int k = 0; k < 4; k++) bq.push_back(k == b ? 2 : 1);
      settle();
      chk(lw_cnt == 1, "R7", "late inhibit ignored", 128'(lw_cnt), 128'(1));
    end

    // R8 R9: error on the opening beat, reported once on re-request
    clr();
    a = 32'h0000_4000;
    fq.push_back(a + 4); bq.push_back(3);
    settle();
    chk(errf_cnt == 1 && lw_cnt == 0, "R9", "deferred error",
        128'({errf_cnt, lw_cnt}), 128'({32'd1, 32'd0}));
    fq.push_back(a + 4); push_beats(4, 1);
    settle();
    chk(errf_cnt == 1 && lw_cnt == 1, "R9", "error cleared after report",
        128'({errf_cnt, lw_cnt}), 128'({32'd1, 32'd1}));

    // R10: opening-beat error, then the fetch unit moves to another word
    clr();
    a = 32'h0000_5000;
    fq.push_back(a + 4); bq.push_back(3);
    do @(negedge clk); while (!(bus_req && bus_ack && bus_err));
    @(posedge clk); #2;
    fq.delete(); fq.push_back(a + 8); drive_fetch();
    push_beats(4, 1);
    settle();
    chk(errf_cnt == 0 && lw_cnt == 1 && ack_cnt == 1, "R10", "retry fill",
        128'({errf_cnt, lw_cnt, ack_cnt}), 128'({32'd0, 32'd1, 32'd1}));

    // R11: error on beats two to four
    for (int b = 1; b < 4; b++) begin
      clr();
      a = 32'h0000_6000 + 32'(b) * 32'h40;
      for (int k = 0; k < 4; k++) fq.push_back(a + 32'(k) * 4);
      push_beats(b, 1); bq.push_back(3);
      push_beats(4, 1);
      settle();
      chk(errf_cnt == 0 && lw_cnt == 1, "R11", "late error discards",
          128'({errf_cnt, lw_cnt}), 128'({32'd0, 32'd1}));
    end

    summary();
    $finish;
  end

endmodule